// File: doc/BRIEF.md
# Flash Page Programming Launch Controller

This block is the control side of an on-chip flash programming path. Software fills a 128-byte page buffer by writing into the code address range while the buffer is mapped. It then arms and fires a two-write key sequence in a control register. That sequence starts a timed operation that copies the buffer into one of three targets: a page of the user array, the single extra row, or the security byte. A mode field in the same register picks the target. It also selects which space a code read sees. The flash cells are a plain behavioural memory, and the program time is a fixed cycle count set by a parameter.

While the operation runs, a busy bit is raised. Code reads are refused, and all writes to the buffer or the control register are dropped. When the operation ends, the buffer is refilled with erased bytes (FFh), ready for the next page.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset the status reads 00h (not busy, buffer unmapped, mode 00). Every user-array, extra-row and buffer byte is FFh. The security byte is {Fh, SEC_LO}.
- R2: A buffer write is accepted only when the map bit is 1, the design is not busy and lat_addr[15] is 0. It stores lat_wdata at byte lat_addr[6:0] and records lat_addr[14:7] (modulo the modelled page count) as the target page. Any other buffer write changes nothing.
- R3: Control write layout: ctl_wdata[7:4] is the key, [2] is the map bit and [1:0] is the mode (00 user, 01 extra row, 10 security, 11 none). Every accepted control write updates map and mode. Status read: ctl_rdata[3] is busy, [2] is map, [1:0] is mode, and [7:4] is zero.
- R4: An accepted control write with key 5h arms the sequence. A following accepted control write with key Ah launches. Ah without a preceding 5h does not launch. Any key other than 5h leaves the sequence disarmed.
- R5: A key Ah write with mode 11 never launches, and busy stays 0.
- R6: Busy rises on the cycle after the launching write and stays high for exactly PROG_CYCLES cycles. Control and buffer writes made while busy are ignored.
- R7: While busy, rd_valid is 0 and rd_data is FFh. Otherwise rd_valid is 1.
- R8: Completion in mode 00 replaces all 128 bytes of the recorded page with the buffer contents.
- R9: Completion in mode 01 replaces the extra row. In read mode 01, addresses FF80h–FFFFh return extra-row byte addr[6:0], and lower addresses return the user array.
- R10: Completion in mode 10 copies buffer byte 0 bits [7:4] into the security byte's upper nibble. The lower nibble stays SEC_LO. In read mode 10, address 0000h returns the security byte, and other addresses return the user array.
- R11: On completion every buffer byte becomes FFh.
- R12: In read modes 00 and 11, rd_data is the user-array byte at rd_addr modulo the array size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lat_we | input | 1 | Write strobe into the code range |
| lat_addr | input | 16 | Code-range write address |
| lat_wdata | input | 8 | Code-range write data |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write value (key, map, mode) |
| ctl_rdata | output | 8 | Status (busy, map, mode) |
| rd_addr | input | 16 | Code read address |
| rd_data | output | 8 | Code read data in the selected space |
| rd_valid | output | 1 | Code read permitted (not busy) |

## Verification
If the unlock state were wrong, busy would rise one cycle after a stray Ah write, or would not rise after a correct pair, and the status read would show it at once. If the program counter or target register were wrong, the busy time would be off or the wrong page or space would be written. Reading every byte back after each operation catches that within a page sweep. A buffer that is not cleared, or a write taken while busy, shows up when a second operation is launched on an unfilled buffer and the target page does not read back as all FFh.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  localparam logic [3:0] KEY_ARM = 4'h5;
  localparam logic [3:0] KEY_GO  = 4'hA;

  typedef enum logic [1:0] {
    SP_USER = 2'b00,
    SP_XROW = 2'b01,
    SP_SEC  = 2'b10,
    SP_NONE = 2'b11
  } space_e;

  // Upper nibble comes from software, lower nibble is kept.
  function automatic logic [7:0] sec_merge(input logic [7:0] cur, input logic [7:0] sw);
    return {sw[7:4], cur[3:0]};
  endfunction

  // True when the address falls into the extra-row read window.
  function automatic logic in_xrow(input logic [15:0] addr);
    return addr[15:7] == 9'h1FF;
  endfunction
endpackage

// File: rtl/flash_key_seq.sv
module flash_key_seq
  import flash_prog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [3:0] key,
  input  space_e     mode,
  output logic       launch,
  output logic       armed
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  armed_q <= 1'b0;
    else if (wr) armed_q <= (key == KEY_ARM);
  end

  assign armed  = armed_q;
  assign launch = wr && armed_q && (key == KEY_GO) && (mode != SP_NONE);
endmodule

// File: rtl/flash_col_latch.sv
module flash_col_latch #(
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned BYTES = 1 << ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    waddr,
  input  logic [7:0]           wdata,
  input  logic                 clr,
  output logic [BYTES*8-1:0]   flat
);
  logic [7:0] mem [BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= 8'hFF;
    end else if (clr) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= 8'hFF;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_flat
    assign flat[g*8 +: 8] = mem[g];
  end
endmodule

// File: rtl/flash_array_model.sv
module flash_array_model
  import flash_prog_pkg::*;
#(
  parameter int unsigned PAGE_W = 3,
  parameter logic [3:0]  SEC_LO = 4'hA,
  localparam int unsigned BYTE_W = 7,
  localparam int unsigned BYTES  = 1 << BYTE_W,
  localparam int unsigned UIDX_W = PAGE_W + BYTE_W,
  localparam int unsigned USIZE  = 1 << UIDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 commit,
  input  space_e               space,
  input  logic [PAGE_W-1:0]    page,
  input  logic [BYTES*8-1:0]   latch_flat,
  input  logic [15:0]          rd_addr,
  input  space_e               rd_space,
  output logic [7:0]           rd_data
);
  logic [7:0] user_mem [USIZE];
  logic [7:0] xrow_mem [BYTES];
  logic [7:0] sec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < USIZE; i++) user_mem[i] <= 8'hFF;
      for (int i = 0; i < BYTES; i++) xrow_mem[i] <= 8'hFF;
      sec_q <= {4'hF, SEC_LO};
    end else if (commit) begin
      case (space)
        SP_USER: for (int i = 0; i < BYTES; i++)
                   user_mem[{page, BYTE_W'(i)}] <= latch_flat[i*8 +: 8];
        SP_XROW: for (int i = 0; i < BYTES; i++)
                   xrow_mem[i] <= latch_flat[i*8 +: 8];
        SP_SEC:  sec_q <= sec_merge(sec_q, latch_flat[7:0]);
        default: ;
      endcase
    end
  end

  logic [7:0] user_rd;
  assign user_rd = user_mem[rd_addr[UIDX_W-1:0]];

  always_comb begin
    rd_data = user_rd;
    case (rd_space)
      SP_XROW: if (in_xrow(rd_addr)) rd_data = xrow_mem[rd_addr[BYTE_W-1:0]];
      SP_SEC:  if (rd_addr == 16'h0000) rd_data = sec_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int unsigned PAGE_W      = 3,
  parameter int unsigned PROG_CYCLES = 64,
  parameter logic [3:0]  SEC_LO      = 4'hA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lat_we,
  input  logic [15:0] lat_addr,
  input  logic [7:0]  lat_wdata,
  input  logic        ctl_we,
  input  logic [7:0]  ctl_wdata,
  output logic [7:0]  ctl_rdata,
  input  logic [15:0] rd_addr,
  output logic [7:0]  rd_data,
  output logic        rd_valid
);
  localparam int unsigned BYTE_W = 7;
  localparam int unsigned BYTES  = 1 << BYTE_W;
  localparam int unsigned CNT_W  = $clog2(PROG_CYCLES + 1);

  logic               busy_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               map_q;
  space_e             mode_q;
  space_e             tgt_q;
  logic [PAGE_W-1:0]  page_q;

  // Named events for the checker
  logic ctl_acc, lat_acc, launch_ev, done_ev, key_armed;
  logic [BYTES*8-1:0] lat_flat;
  logic [7:0] latch_b0;
  logic [7:0] arr_rd;
  space_e wr_mode;

  assign wr_mode  = space_e'(ctl_wdata[1:0]);
  assign ctl_acc  = ctl_we && !busy_q;
  assign lat_acc  = lat_we && !busy_q && map_q && !lat_addr[15];
  assign done_ev  = busy_q && (cnt_q == '0);
  assign latch_b0 = lat_flat[7:0];

  flash_key_seq u_key (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (ctl_acc),
    .key    (ctl_wdata[7:4]),
    .mode   (wr_mode),
    .launch (launch_ev),
    .armed  (key_armed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      map_q  <= 1'b0;
      mode_q <= SP_USER;
      tgt_q  <= SP_USER;
      page_q <= '0;
    end else begin
      if (ctl_acc) begin
        map_q  <= ctl_wdata[2];
        mode_q <= wr_mode;
      end
      if (launch_ev) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(PROG_CYCLES - 1);
        tgt_q  <= wr_mode;
      end else if (done_ev) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (lat_acc) page_q <= lat_addr[BYTE_W +: PAGE_W];
    end
  end

  flash_col_latch #(.ADDR_W(BYTE_W)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (lat_acc),
    .waddr (lat_addr[BYTE_W-1:0]),
    .wdata (lat_wdata),
    .clr   (done_ev),
    .flat  (lat_flat)
  );

  flash_array_model #(.PAGE_W(PAGE_W), .SEC_LO(SEC_LO)) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (done_ev),
    .space      (tgt_q),
    .page       (page_q),
    .latch_flat (lat_flat),
    .rd_addr    (rd_addr),
    .rd_space   (mode_q),
    .rd_data    (arr_rd)
  );

  assign rd_valid  = !busy_q;
  assign rd_data   = busy_q ? 8'hFF : arr_rd;
  assign ctl_rdata = {4'b0000, busy_q, map_q, mode_q};
endmodule

// File: rtl/flash_prog_ctrl_chk.sv
module flash_prog_ctrl_chk #(
  parameter int unsigned PROG_CYCLES = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic [7:0] ctl_wdata,
  input logic [7:0] ctl_rdata,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       done_ev,
  input logic [7:0] latch_b0
);
  logic busy;
  logic [31:0] busy_len;
  assign busy = ctl_rdata[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 32'd0;
    else if (busy) busy_len <= busy_len + 32'd1;
    else           busy_len <= 32'd0;
  end

  // R4: busy only rises after a write carrying key Ah
  a_r4_launch_on_go: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(ctl_we) && $past(ctl_wdata[7:4]) == 4'hA));

  // R5: mode 11 never starts an operation
  a_r5_none_mode_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ctl_wdata[1:0]) != 2'b11);

  // R6: exact busy duration
  a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == PROG_CYCLES);

  // R6: control writes while busy leave map and mode alone
  a_r6_ctl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_we) |=> ctl_rdata[2:0] == $past(ctl_rdata[2:0]));

  // R7: reads refused while busy
  a_r7_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!rd_valid && rd_data == 8'hFF));

  // R11: buffer erased after completion
  a_r11_latch_erased: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> latch_b0 == 8'hFF);
endmodule

bind flash_prog_ctrl flash_prog_ctrl_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_we    (ctl_we),
  .ctl_wdata (ctl_wdata),
  .ctl_rdata (ctl_rdata),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .done_ev   (done_ev),
  .latch_b0  (latch_b0)
);

// File: tb/test_flash_prog_ctrl.sv
module test_flash_prog_ctrl;
  localparam int PW    = 2;
  localparam int PC    = 5;
  localparam logic [3:0] SLO = 4'h6;
  localparam int USZ   = 1 << (PW + 7);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lat_we = 1'b0;
  logic [15:0] lat_addr = '0;
  logic [7:0]  lat_wdata = '0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [7:0]  ctl_rdata;
  logic [15:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        rd_valid;

  always #4 clk = ~clk;

  flash_prog_ctrl #(.PAGE_W(PW), .PROG_CYCLES(PC), .SEC_LO(SLO)) i_flash_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .lat_we(lat_we), .lat_addr(lat_addr),
    .lat_wdata(lat_wdata), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] user_m [USZ];
  logic [7:0] xrow_m [128];
  logic [7:0] lat_m  [128];
  logic [7:0] sec_m;
  int         page_m;
  logic       map_m;

  function automatic logic [7:0] pat(int p, int i);
    return 8'((p * 37 + i * 5 + 1) & 255);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic [3:0] key, input logic map, input logic [1:0] mode);
    ctl_we = 1'b1;
    ctl_wdata = {key, 1'b0, map, mode};
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic lw(input logic [15:0] a, input logic [7:0] d);
    lat_we = 1'b1; lat_addr = a; lat_wdata = d;
    @(negedge clk);
    lat_we = 1'b0;
    if (map_m && !a[15]) begin
      lat_m[a[6:0]] = d;
      page_m = int'(a[8:7]);
    end
  endtask

  task automatic rchk(input string req, input logic [15:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
    chk(req, rd_valid, 1);
  endtask

  task automatic commit_model(input logic [1:0] mode);
    case (mode)
      2'b00: for (int i = 0; i < 128; i++) user_m[page_m * 128 + i] = lat_m[i];
      2'b01: for (int i = 0; i < 128; i++) xrow_m[i] = lat_m[i];
      2'b10: sec_m = {lat_m[0][7:4], sec_m[3:0]};
      default: ;
    endcase
    for (int i = 0; i < 128; i++) lat_m[i] = 8'hFF;
  endtask

  // R4/R6: key pair then busy for exactly PC cycles
  task automatic prog(input logic [1:0] mode);
    ctl(4'h5, map_m, mode);
    ctl(4'hA, map_m, mode);
    for (int k = 0; k < PC; k++) begin
      chk("R6 busy high", ctl_rdata[3], 1);
      @(negedge clk);
    end
    chk("R6 busy low after", ctl_rdata[3], 0);
    commit_model(mode);
  endtask

  task automatic check_user(input string req);
    for (int i = 0; i < USZ; i++) rchk(req, 16'(i), user_m[i]);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < USZ; i++) user_m[i] = 8'hFF;
    for (int i = 0; i < 128; i++) begin xrow_m[i] = 8'hFF; lat_m[i] = 8'hFF; end
    sec_m = {4'hF, SLO};
    page_m = 0; map_m = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 status", ctl_rdata, 8'h00);
    check_user("R1 user erased");
    ctl(4'h0, 1'b0, 2'b10);
    chk("R3 status mode", ctl_rdata, 8'h02);
    rchk("R1 security reset", 16'h0000, {4'hF, SLO});
    ctl(4'h0, 1'b0, 2'b01);
    for (int i = 0; i < 128; i++) rchk("R1 xrow erased", 16'hFF80 + 16'(i), 8'hFF);

    // R2 R8: fill and program every page
    map_m = 1'b1;
    ctl(4'h0, 1'b1, 2'b00);
    chk("R3 status map", ctl_rdata, 8'h04);
    for (int p = 0; p < (1 << PW); p++) begin
      for (int i = 0; i < 128; i++) lw(16'(p * 128 + i), pat(p, i));
      prog(2'b00);
      check_user("R8 page programmed");
    end

    // R12 wrap of high addresses
    rchk("R12 wrap", 16'hFE05, user_m[16'hFE05 % USZ]);
    rchk("R12 wrap2", 16'h8181, user_m[16'h8181 % USZ]);

    // R2 ignored writes: upper range, then unmapped
    lw(16'h8005, 8'h5A);
    map_m = 1'b0;
    ctl(4'h0, 1'b0, 2'b00);
    lw(16'h0007, 8'h77);
    prog(2'b00);
    chk("R2 ignored writes page", user_m[3 * 128 + 5], 8'hFF);
    check_user("R2 ignored writes");

    // R4 key misuse
    ctl(4'hA, 1'b0, 2'b00);
    chk("R4 A alone", ctl_rdata[3], 0);
    ctl(4'h5, 1'b0, 2'b00);
    ctl(4'h3, 1'b0, 2'b00);
    ctl(4'hA, 1'b0, 2'b00);
    chk("R4 5 then 3 then A", ctl_rdata[3], 0);
    ctl(4'h5, 1'b0, 2'b00);
    @(negedge clk); @(negedge clk);
    chk("R4 5 alone", ctl_rdata[3], 0);
    // R5 mode 11
    ctl(4'h5, 1'b0, 2'b11);
    ctl(4'hA, 1'b0, 2'b11);
    chk("R5 mode none", ctl_rdata[3], 0);
    @(negedge clk);
    chk("R5 mode none later", ctl_rdata[3], 0);
    check_user("R5 user untouched");

    // R9 extra row
    map_m = 1'b1;
    ctl(4'h0, 1'b1, 2'b01);
    for (int i = 0; i < 128; i++) lw(16'h0100 + 16'(i), pat(9, i));
    prog(2'b01);
    for (int i = 0; i < 128; i++) rchk("R9 xrow", 16'hFF80 + 16'(i), xrow_m[i]);
    rchk("R9 below window", 16'h0010, user_m[16'h0010]);
    rchk("R9 just below", 16'hFF7F, user_m[16'hFF7F % USZ]);
    ctl(4'h0, 1'b1, 2'b00);
    check_user("R9 user kept");

    // R10 security
    ctl(4'h0, 1'b1, 2'b10);
    lw(16'h0000, 8'h3C);
    prog(2'b10);
    rchk("R10 security", 16'h0000, {4'h3, SLO});
    rchk("R10 other addr", 16'h0001, user_m[1]);

    // R6 R7: activity while busy
    ctl(4'h0, 1'b1, 2'b00);
    for (int i = 0; i < 128; i++) lw(16'h0100 + 16'(i), pat(5, i));
    ctl(4'h5, 1'b1, 2'b00);
    ctl(4'hA, 1'b1, 2'b00);
    rd_addr = 16'h0100; #1;
    chk("R7 valid low", rd_valid, 0);
    chk("R7 data FF", rd_data, 8'hFF);
    ctl(4'h0, 1'b0, 2'b11);
    lat_we = 1'b1; lat_addr = 16'h0103; lat_wdata = 8'h12;
    @(negedge clk);
    lat_we = 1'b0;
    for (int k = 0; k < 20 && ctl_rdata[3]; k++) @(negedge clk);
    chk("R6 status kept", ctl_rdata, 8'h04);
    commit_model(2'b00);
    check_user("R8 busy-run page");

    // R11 buffer erased: program again without filling
    prog(2'b00);
    chk("R11 byte3 erased", user_m[2 * 128 + 3], 8'hFF);
    check_user("R11 page erased");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule